// File: doc/BRIEF.md
# Dual Programmable Timer/Counter

This block gives a processor two independent timer/counters behind one small synchronous register bus. Each timer has a control/status register, a preset register and a live count register. It can count up or down and can run once or reload itself on expiry. Software can force the count to the preset value. On each expiry the timer raises a sticky event flag, and software clears that flag by writing a one to it. A single interrupt line combines the flags of both timers, each gated by its own enable.

A typical use runs one timer as a periodic down-counting tick source with its interrupt enabled. The other timer then counts up freely as a timestamp, and software reads it whenever it needs the time. Several control bits (event capture, external pulse output, pulse-width pairing and joint start) are kept in the register and read back as written, but they have no effect on counting.

Top module: `twin_timer`

## Requirements
- R1: After reset, every control, preset and count register reads zero, `irq` is low and `rdData` is zero.
- R2: Timer n has its control register at byte offset 0x10*n+0x0, its preset register at +0x4 and its count register at +0x8. The count register is read-only, and writes to it are ignored. Reads of any other offset return zero. Read data appears on `rdData` one cycle after `rdEn` and holds until the next read. Control bits 0, 2, 3, 9 and 10 are stored and read back as written, but they do not change counting.
- R3: While control bit 5 (preset) is 1, the count register takes the preset value on every edge and does not count. Counting starts from that value once software writes the control register with bit 5 cleared.
- R4: With bit 7 (run) = 1, bit 1 (down) = 1 and bit 4 (reload) = 1, the count drops by one each cycle. From zero it reloads the preset value, sets the flag (bit 8) and keeps running, so it expires every preset+1 cycles.
- R5: With bit 1 = 0, the count rises by one each cycle. From 0xFFFFFFFF with reload set, it takes the preset value and sets the flag, so a preset of zero wraps it through the whole 32-bit range.
- R6: With bit 4 = 0, an expiry sets the flag, holds the terminal count and clears bit 7.
- R7: With bit 7 = 0, the count holds its value. Setting bit 7 again resumes counting from that value.
- R8: Writing 1 to bit 8 clears the flag and writing 0 leaves it unchanged. Writing back a value just read clears a pending flag and keeps every other setting.
- R9: A flag-clearing write in the same cycle as a new expiry leaves the flag set.
- R10: `irq` is high exactly when some timer has both its flag (bit 8) and its interrupt enable (bit 6) set.
- R11: Accesses to one timer and the state of that timer never change the other timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 5 | Byte offset of the register accessed |
| wrEn | input | 1 | Write strobe for this cycle |
| wrData | input | 32 | Write data |
| rdEn | input | 1 | Read strobe for this cycle |
| rdData | output | 32 | Registered read data |
| irq | output | 1 | Combined interrupt request |

## Verification
Every result appears a set number of edges after its cause. Read data and a new count both appear one edge after the strobe or control write. A preset takes hold one edge after the control register holds bit 5. The flag and `irq` rise on the edge where the count leaves its terminal value. A read captures the count as it stood before the read's edge. The stimulus table therefore gives each row exactly one clock cycle and samples results on the falling edge after that row's rising edge. The expected values in each row come from counting those edges.

// File: rtl/twin_timer_pkg.sv
package twin_timer_pkg;

  // control/status bit positions (software-visible)
  localparam int BIT_CAPMODE = 0;
  localparam int BIT_DOWN    = 1;
  localparam int BIT_PULSEOE = 2;
  localparam int BIT_CAPEN   = 3;
  localparam int BIT_AUTO    = 4;
  localparam int BIT_PRESET  = 5;
  localparam int BIT_IEN     = 6;
  localparam int BIT_RUN     = 7;
  localparam int BIT_FLAG    = 8;
  localparam int BIT_PAIR    = 9;
  localparam int BIT_JOINT   = 10;
  localparam int CSR_W       = 11;

  // register slots within one timer's window
  localparam int SLOT_W    = 4;
  localparam int SLOT_CSR  = 'h0;
  localparam int SLOT_LOAD = 'h4;
  localparam int SLOT_CNT  = 'h8;

  typedef struct packed {
    logic csrWr;
    logic loadWr;
  } tmrStrobe_t;

endpackage

// File: rtl/twin_timer_ctrl.sv
module twin_timer_ctrl
  import twin_timer_pkg::*;
#(
  parameter int NUM_TMR = 2,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [CSR_W-1:0]  csrAll  [NUM_TMR],
  input  logic [DATA_W-1:0] loadAll [NUM_TMR],
  input  logic [DATA_W-1:0] cntAll  [NUM_TMR],
  output tmrStrobe_t        strb    [NUM_TMR],
  output logic [DATA_W-1:0] rdData
);

  localparam int IDX_W = ADDR_W - SLOT_W;

  logic [IDX_W-1:0]  tmrIdx;
  logic [SLOT_W-1:0] slot;
  logic              idxHit;
  logic [DATA_W-1:0] rdNext;

  assign tmrIdx = addr[ADDR_W-1:SLOT_W];
  assign slot   = addr[SLOT_W-1:0];
  assign idxHit = (int'(tmrIdx) < NUM_TMR);

  always_comb begin
    for (int i = 0; i < NUM_TMR; i++) begin
      strb[i].csrWr  = wrEn && (tmrIdx == IDX_W'(i)) && (slot == SLOT_W'(SLOT_CSR));
      strb[i].loadWr = wrEn && (tmrIdx == IDX_W'(i)) && (slot == SLOT_W'(SLOT_LOAD));
    end
  end

  always_comb begin
    rdNext = '0;
    if (idxHit) begin
      if (slot == SLOT_W'(SLOT_CSR))
        rdNext = DATA_W'(csrAll[tmrIdx]);
      else if (slot == SLOT_W'(SLOT_LOAD))
        rdNext = loadAll[tmrIdx];
      else if (slot == SLOT_W'(SLOT_CNT))
        rdNext = cntAll[tmrIdx];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     rdData <= '0;
    else if (rdEn) rdData <= rdNext;
  end

endmodule

// File: rtl/twin_timer_path.sv
module twin_timer_path
  import twin_timer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmrStrobe_t        strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [CSR_W-1:0]  csrQ,
  output logic [DATA_W-1:0] loadQ,
  output logic [DATA_W-1:0] cntQ,
  output logic              reqO
);

  logic             running;
  logic             atEnd;
  logic             expire;
  logic [CSR_W-1:0] csrNext;

  assign running = csrQ[BIT_RUN] & ~csrQ[BIT_PRESET];
  assign atEnd   = csrQ[BIT_DOWN] ? (cntQ == '0) : (cntQ == '1);
  assign expire  = running & atEnd;
  assign reqO    = csrQ[BIT_FLAG] & csrQ[BIT_IEN];

  always_comb begin
    csrNext = csrQ;
    if (strb.csrWr) begin
      csrNext           = wrData[CSR_W-1:0];
      csrNext[BIT_FLAG] = csrQ[BIT_FLAG] & ~wrData[BIT_FLAG];
    end else if (expire && !csrQ[BIT_AUTO]) begin
      csrNext[BIT_RUN] = 1'b0;
    end
    if (expire) csrNext[BIT_FLAG] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csrQ  <= '0;
      loadQ <= '0;
      cntQ  <= '0;
    end else begin
      csrQ <= csrNext;
      if (strb.loadWr) loadQ <= wrData;
      if (csrQ[BIT_PRESET]) begin
        cntQ <= loadQ;
      end else if (running) begin
        if (expire) begin
          if (csrQ[BIT_AUTO]) cntQ <= loadQ;
        end else if (csrQ[BIT_DOWN]) begin
          cntQ <= cntQ - DATA_W'(1);
        end else begin
          cntQ <= cntQ + DATA_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/twin_timer.sv
module twin_timer
  import twin_timer_pkg::*;
#(
  parameter int  NUM_TMR = 2,
  parameter int  DATA_W  = 32,
  localparam int ADDR_W  = $clog2(NUM_TMR) + SLOT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);

  tmrStrobe_t        strb    [NUM_TMR];
  logic [CSR_W-1:0]  csrAll  [NUM_TMR];
  logic [DATA_W-1:0] loadAll [NUM_TMR];
  logic [DATA_W-1:0] cntAll  [NUM_TMR];
  logic [NUM_TMR-1:0] reqVec;

  twin_timer_ctrl #(.NUM_TMR(NUM_TMR), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .csrAll(csrAll), .loadAll(loadAll), .cntAll(cntAll),
    .strb(strb), .rdData(rdData)
  );

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    twin_timer_path #(.DATA_W(DATA_W)) u_path (
      .clk(clk), .rstN(rstN), .strb(strb[g]), .wrData(wrData),
      .csrQ(csrAll[g]), .loadQ(loadAll[g]), .cntQ(cntAll[g]), .reqO(reqVec[g])
    );
  end

  assign irq = |reqVec;

endmodule

// File: rtl/twin_timer_chk.sv
module twin_timer_chk
  import twin_timer_pkg::*;
#(
  parameter int NUM_TMR = 2,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic              wrEn,
  input logic [DATA_W-1:0] wrData,
  input logic              rdEn,
  input logic [DATA_W-1:0] rdData,
  input logic [CSR_W-1:0]  csrAll  [NUM_TMR],
  input logic [DATA_W-1:0] loadAll [NUM_TMR],
  input logic [DATA_W-1:0] cntAll  [NUM_TMR]
);

  assert_unmapped_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr[SLOT_W-1:0] == SLOT_W'('hC)) |=> (rdData == '0));

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_chk
    logic csrWrHere;
    logic live;
    assign csrWrHere = wrEn && (addr == ADDR_W'(g * (1 << SLOT_W) + SLOT_CSR));
    assign live      = csrAll[g][BIT_RUN] && !csrAll[g][BIT_PRESET];

    assert_preset_R3: assert property (@(posedge clk) disable iff (!rstN)
      csrAll[g][BIT_PRESET] |=> (cntAll[g] == $past(loadAll[g])));

    assert_step_down_R4: assert property (@(posedge clk) disable iff (!rstN)
      (live && csrAll[g][BIT_DOWN] && cntAll[g] != '0)
      |=> (cntAll[g] + DATA_W'(1) == $past(cntAll[g])));

    assert_reload_R4: assert property (@(posedge clk) disable iff (!rstN)
      (live && csrAll[g][BIT_DOWN] && csrAll[g][BIT_AUTO] && cntAll[g] == '0)
      |=> (cntAll[g] == $past(loadAll[g]) && csrAll[g][BIT_FLAG]));

    assert_wrap_R5: assert property (@(posedge clk) disable iff (!rstN)
      (live && !csrAll[g][BIT_DOWN] && csrAll[g][BIT_AUTO] && cntAll[g] == '1)
      |=> (cntAll[g] == $past(loadAll[g])));

    assert_oneshot_R6: assert property (@(posedge clk) disable iff (!rstN)
      (live && !csrAll[g][BIT_AUTO] && !csrWrHere &&
       (csrAll[g][BIT_DOWN] ? cntAll[g] == '0 : cntAll[g] == '1))
      |=> (!csrAll[g][BIT_RUN] && csrAll[g][BIT_FLAG] && $stable(cntAll[g])));

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
      (!csrAll[g][BIT_RUN] && !csrAll[g][BIT_PRESET]) |=> $stable(cntAll[g]));

    assert_flag_keep_R9: assert property (@(posedge clk) disable iff (!rstN)
      (csrAll[g][BIT_FLAG] && !(csrWrHere && wrData[BIT_FLAG])) |=> csrAll[g][BIT_FLAG]);
  end

endmodule

bind twin_timer twin_timer_chk #(.NUM_TMR(NUM_TMR), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
  .rdEn(rdEn), .rdData(rdData),
  .csrAll(csrAll), .loadAll(loadAll), .cntAll(cntAll)
);

// File: tb/twin_timer_bench.sv
`timescale 1ns/1ps
module twin_timer_bench;

  typedef struct packed {
    logic        wr;
    logic        rd;
    logic [4:0]  a;
    logic [31:0] d;
    logic [31:0] exp;
    logic        irqExp;
    logic [3:0]  req;
  } vec_t;

  function automatic vec_t wrRow(logic [4:0] a, logic [31:0] d, logic q, int r);
    return '{wr: 1'b1, rd: 1'b0, a: a, d: d, exp: 32'h0, irqExp: q, req: 4'(r)};
  endfunction
  function automatic vec_t rdRow(logic [4:0] a, logic [31:0] e, logic q, int r);
    return '{wr: 1'b0, rd: 1'b1, a: a, d: 32'h0, exp: e, irqExp: q, req: 4'(r)};
  endfunction
  function automatic vec_t idleRow(logic q, int r);
    return '{wr: 1'b0, rd: 1'b0, a: 5'h0, d: 32'h0, exp: 32'h0, irqExp: q, req: 4'(r)};
  endfunction

  localparam int NV = 57;
  // one row = one clock cycle; rd rows check the value before that row's edge
  localparam vec_t VECS [NV] = '{
    rdRow(5'h00, 32'h0, 0, 1),            // R1 reset value
    wrRow(5'h04, 32'd3, 0, 2),
    rdRow(5'h04, 32'd3, 0, 2),            // R2 preset readback
    wrRow(5'h00, 32'h020, 0, 3),          // R3 preset on
    rdRow(5'h00, 32'h020, 0, 2),
    rdRow(5'h08, 32'd3, 0, 3),            // R3 forced
    wrRow(5'h00, 32'h0D2, 0, 3),          // run, ien, auto, down
    rdRow(5'h08, 32'd3, 0, 3),
    rdRow(5'h08, 32'd2, 0, 4),            // R4 decrement
    idleRow(0, 4),
    idleRow(1, 10),                       // R10 expiry raises irq
    rdRow(5'h08, 32'd3, 1, 4),            // R4 reload
    rdRow(5'h00, 32'h1D2, 1, 4),
    wrRow(5'h00, 32'h1D2, 0, 8),          // R8 write-back clears flag
    rdRow(5'h00, 32'h0D2, 1, 8),          // R8 settings kept; R4 next tick
    idleRow(1, 4), idleRow(1, 4), idleRow(1, 4),
    wrRow(5'h00, 32'h1D2, 1, 9),          // R9 clear with expiry
    rdRow(5'h00, 32'h1D2, 1, 9),
    wrRow(5'h00, 32'h152, 0, 7),          // R7 stop
    idleRow(0, 7),
    rdRow(5'h08, 32'd1, 0, 7),
    rdRow(5'h08, 32'd1, 0, 7),
    wrRow(5'h00, 32'h0D2, 0, 7),          // R7 resume
    rdRow(5'h08, 32'd1, 0, 7),
    rdRow(5'h08, 32'd0, 1, 7),
    wrRow(5'h00, 32'h100, 0, 8),
    wrRow(5'h10, 32'h0D0, 0, 5),          // R5 timer 1 up, free
    rdRow(5'h18, 32'd0, 0, 5),
    rdRow(5'h18, 32'd1, 0, 5),
    rdRow(5'h08, 32'd2, 0, 11),           // R11 timer 0 untouched
    wrRow(5'h14, 32'hFFFF_FFFD, 0, 3),
    wrRow(5'h10, 32'h0F0, 0, 3),
    wrRow(5'h10, 32'h0D0, 0, 3),
    wrRow(5'h14, 32'h0, 0, 5),
    rdRow(5'h18, 32'hFFFF_FFFE, 0, 5),
    rdRow(5'h18, 32'hFFFF_FFFF, 1, 5),
    rdRow(5'h18, 32'h0, 1, 5),            // R5 wrap to zero
    rdRow(5'h10, 32'h1D0, 1, 10),
    wrRow(5'h10, 32'h090, 0, 10),         // R10 ien off masks irq
    rdRow(5'h10, 32'h190, 0, 8),          // R8 writing 0 keeps flag
    wrRow(5'h10, 32'h100, 0, 8),
    wrRow(5'h04, 32'd1, 0, 6),
    wrRow(5'h00, 32'h6EF, 0, 6),          // R6 one-shot plus inert bits
    wrRow(5'h00, 32'h6CF, 0, 6),
    rdRow(5'h08, 32'd1, 0, 6),
    idleRow(1, 6), idleRow(1, 6),
    rdRow(5'h08, 32'd0, 1, 6),            // R6 holds terminal
    rdRow(5'h00, 32'h74F, 1, 2),          // R2 inert bits; R6 run cleared
    wrRow(5'h08, 32'h1234, 1, 2),         // R2 count is read-only
    rdRow(5'h08, 32'd0, 1, 2),
    rdRow(5'h0C, 32'h0, 1, 2),            // R2 unmapped
    rdRow(5'h1C, 32'h0, 1, 2),
    wrRow(5'h00, 32'h100, 0, 8),
    rdRow(5'h00, 32'h0, 0, 8)
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  addr = '0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic        rdEn = 1'b0;
  logic [31:0] rdData;
  logic        irq;
  int          total = 0;
  int          bad = 0;
  logic        done = 1'b0;

  always #2 clk = ~clk;

  twin_timer u_twin_timer (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .irq(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic readAt(logic [4:0] a, output logic [31:0] v);
    addr = a; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    v = rdData;
  endtask

  initial begin : main
    logic [31:0] v;
    repeat (3) @(negedge clk);
    check("R1", {31'b0, irq}, 32'h0);
    check("R1", rdData, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      wrEn = VECS[i].wr; rdEn = VECS[i].rd;
      addr = VECS[i].a;  wrData = VECS[i].d;
      @(negedge clk);
      if (VECS[i].rd) check($sformatf("R%0d row %0d", VECS[i].req, i), rdData, VECS[i].exp);
      check($sformatf("R%0d row %0d irq", VECS[i].req, i), {31'b0, irq}, {31'b0, VECS[i].irqExp});
    end
    wrEn = 1'b0; rdEn = 1'b0;
    // R1: reset mid-run clears preset (timer 0 holds 1) and read data
    readAt(5'h04, v);
    check("R1 pre", v, 32'd1);
    rstN = 1'b0;
    @(negedge clk);
    check("R1 rd", rdData, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    readAt(5'h04, v); check("R1 load0", v, 32'h0);
    readAt(5'h14, v); check("R1 load1", v, 32'h0);
    readAt(5'h18, v); check("R1 cnt1", v, 32'h0);
    // R11: timer 1 preset write leaves timer 0 preset alone
    addr = 5'h14; wrData = 32'hA5A5; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    readAt(5'h04, v); check("R11", v, 32'h0);
    readAt(5'h14, v); check("R2", v, 32'hA5A5);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog all actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule